// File: doc/BRIEF.md
# Key-Unlocked Configuration Register Bank

This block is a small bank of 32-bit control registers on a word-addressed bus. Each access takes one cycle. Two key registers guard it. A write to a protected register lands only while both key registers hold their magic values. Software opens the bank by writing the two keys, makes its changes, and then closes the bank by writing any other value to a key register. Reads are never blocked.

The bank holds two protected registers: a general control word with fixed reset defaults, and an I/O enable register. It also holds a read-only lock status. A state machine tracks which keys currently match. It has four states:
- `ST_LOCKED`: neither key matches.
- `ST_KEY0_OK`: only key 0 matches.
- `ST_KEY1_OK`: only key 1 matches.
- `ST_OPEN`: both keys match.

Each transition is driven by a write to a key register. A matching value written to a key moves the machine toward `ST_OPEN`. A mismatching value moves it back toward `ST_LOCKED`. The keys may be written in either order. Writes to other addresses leave the state unchanged. The control word drives its fields out as wires. One of these fields is a 2-bit serial-peripheral master select: 00 selects master A, 01 selects master B, and 10 and 11 are reserved.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, the control word is 0x00261889, the I/O enable register and both key registers are 0, and the bank is locked.
- R2: Key 0 is at byte offset 0x07C and key 1 is at byte offset 0x080. Both keys accept writes at all times and read back their last written value.
- R3: The bank is unlocked exactly when key 0 holds 0x20406080 and key 1 holds 0x10305070. The two keys may be written in either order.
- R4: Writing any other value to either key register locks the bank again, starting with the next access.
- R5: A write to the control word (offset 0x000) or to the I/O enable register (offset 0x144) while the bank is locked is dropped, and the register keeps its old value.
- R6: A write to either protected register while the bank is unlocked takes effect at that clock edge.
- R7: The control word's bits 27:26 hold the serial-peripheral master select. An unlocked control-word write that carries 10 or 11 in those bits keeps the previous select, and still updates every other bit.
- R8: Offset 0x0F0 reads back the lock status in bit 0, where 1 means locked and the other bits are 0. Writes to this offset have no effect.
- R9: Reads are allowed whether the bank is locked or not. Reads from unmapped offsets return 0, and writes to unmapped offsets change nothing.
- R10: The `ctrl_word`, `io_enable` and `spi_master_sel` outputs follow the stored registers. `bank_locked` is 1 in every state except `ST_OPEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ctrl_word | output | 32 | Control word value |
| io_enable | output | 32 | I/O enable register value |
| spi_master_sel | output | 2 | Serial-peripheral master select (control word bits 27:26) |
| bank_locked | output | 1 | 1 while protected writes are blocked |

## Verification
The assertions check several rules on every cycle:
- the bank is never open unless both keys hold their magic values;
- a mismatching key write always closes the bank;
- a locked write never changes a protected register;
- an unlocked write lands;
- a reserved master code never reaches the select bits.

Some behaviour can only be shown by the bench's scenarios. These are the exact reset defaults, unlocking in both key orders, read-back of every register, the ignored status and unmapped writes, and long random sequences that mix key writes with protected writes, compared against the bench's own model.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_KEY0_OK = 2'd1,
        ST_KEY1_OK = 2'd2,
        ST_OPEN    = 2'd3
    } lock_state_t;

    localparam logic [31:0] KEY0_MAGIC   = 32'h2040_6080;
    localparam logic [31:0] KEY1_MAGIC   = 32'h1030_5070;
    localparam logic [31:0] CTRL_DEFAULT = 32'h0026_1889;
endpackage

// File: rtl/cfgbank_unlock_fsm.sv
module cfgbank_unlock_fsm
    import cfgbank_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY0 = KEY0_MAGIC,
    parameter logic [DATA_W-1:0] KEY1 = KEY1_MAGIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key0_we,
    input  logic              key1_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] key0_q,
    output logic [DATA_W-1:0] key1_q,
    output logic              locked
);
    lock_state_t state_q, state_d;
    logic k0_ok, k1_ok, k0_next, k1_next;

    // Decode which keys currently match from the state.
    always_comb begin
        k0_ok = 1'b0;
        k1_ok = 1'b0;
        unique case (state_q)
            ST_LOCKED:  begin k0_ok = 1'b0; k1_ok = 1'b0; end
            ST_KEY0_OK: begin k0_ok = 1'b1; k1_ok = 1'b0; end
            ST_KEY1_OK: begin k0_ok = 1'b0; k1_ok = 1'b1; end
            ST_OPEN:    begin k0_ok = 1'b1; k1_ok = 1'b1; end
            default:    begin k0_ok = 1'b0; k1_ok = 1'b0; end
        endcase
        k0_next = key0_we ? (wdata == KEY0) : k0_ok;
        k1_next = key1_we ? (wdata == KEY1) : k1_ok;
        unique case ({k1_next, k0_next})
            2'b00:   state_d = ST_LOCKED;
            2'b01:   state_d = ST_KEY0_OK;
            2'b10:   state_d = ST_KEY1_OK;
            2'b11:   state_d = ST_OPEN;
            default: state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            key0_q  <= '0;
            key1_q  <= '0;
        end else begin
            state_q <= state_d;
            if (key0_we) key0_q <= wdata;
            if (key1_we) key1_q <= wdata;
        end
    end

    always_comb locked = (state_q != ST_OPEN);

    // R3: open only while both stored keys hold the magic values
    p_open_needs_keys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (key0_q == KEY0 && key1_q == KEY1));

    // R4: a mismatching key write always closes the bank
    p_bad_key_relocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((key0_we && wdata != KEY0) || (key1_we && wdata != KEY1)) |=> locked);
endmodule

// File: rtl/cfgbank_prot_regs.sv
module cfgbank_prot_regs
    import cfgbank_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          SEL_LSB = 26,
    parameter int          SEL_W   = 2,
    parameter logic [DATA_W-1:0] CTRL_RST = CTRL_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              ctrl_we,
    input  logic              io_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] io_q
);
    localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

    logic [DATA_W-1:0] ctrl_new;
    logic              sel_reserved;

    // Codes with the top select bit set are reserved; keep the old select.
    always_comb begin
        sel_reserved = wdata[SEL_MSB];
        ctrl_new     = wdata;
        if (sel_reserved) ctrl_new[SEL_MSB:SEL_LSB] = ctrl_q[SEL_MSB:SEL_LSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            io_q   <= '0;
        end else if (!locked) begin
            if (ctrl_we) ctrl_q <= ctrl_new;
            if (io_we)   io_q   <= wdata;
        end
    end

    // R5: locked writes never change protected state
    p_locked_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && (ctrl_we || io_we)) |=> ($stable(ctrl_q) && $stable(io_q)));

    // R6: an unlocked write to the I/O register lands
    p_open_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && io_we) |=> (io_q == $past(wdata)));

    // R7: a reserved select code never reaches the register
    p_sel_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[SEL_MSB] == 1'b0);
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int SEL_LSB  = 26,
    parameter int SEL_W    = 2,
    parameter logic [ADDR_W-1:0] OFS_CTRL   = 12'h000,
    parameter logic [ADDR_W-1:0] OFS_KEY0   = 12'h07C,
    parameter logic [ADDR_W-1:0] OFS_KEY1   = 12'h080,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 12'h0F0,
    parameter logic [ADDR_W-1:0] OFS_IOEN   = 12'h144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] io_enable,
    output logic [SEL_W-1:0]  spi_master_sel,
    output logic              bank_locked
);
    logic              key0_we, key1_we, ctrl_we, io_we, locked;
    logic [DATA_W-1:0] key0_q, key1_q, ctrl_q, io_q;

    always_comb begin
        key0_we = bus_we && (bus_addr == OFS_KEY0);
        key1_we = bus_we && (bus_addr == OFS_KEY1);
        ctrl_we = bus_we && (bus_addr == OFS_CTRL);
        io_we   = bus_we && (bus_addr == OFS_IOEN);
    end

    cfgbank_unlock_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key0_we (key0_we),
        .key1_we (key1_we),
        .wdata   (bus_wdata),
        .key0_q  (key0_q),
        .key1_q  (key1_q),
        .locked  (locked)
    );

    cfgbank_prot_regs #(
        .DATA_W  (DATA_W),
        .SEL_LSB (SEL_LSB),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (locked),
        .ctrl_we (ctrl_we),
        .io_we   (io_we),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .io_q    (io_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL)        bus_rdata = ctrl_q;
        else if (bus_addr == OFS_KEY0)   bus_rdata = key0_q;
        else if (bus_addr == OFS_KEY1)   bus_rdata = key1_q;
        else if (bus_addr == OFS_IOEN)   bus_rdata = io_q;
        else if (bus_addr == OFS_STATUS) bus_rdata[0] = locked;
    end

    always_comb begin
        ctrl_word      = ctrl_q;
        io_enable      = io_q;
        spi_master_sel = ctrl_q[SEL_LSB +: SEL_W];
        bank_locked    = locked;
    end

    // R10: the status read and the lock output agree
    p_status_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STATUS) |-> (bus_rdata == {{(DATA_W-1){1'b0}}, bank_locked}));
endmodule

// File: tb/cfgbank_top_test.sv
module cfgbank_top_test;
    localparam logic [11:0] A_CTRL = 12'h000, A_K0 = 12'h07C, A_K1 = 12'h080,
                            A_STAT = 12'h0F0, A_IO = 12'h144, A_UNM = 12'h200;
    localparam logic [31:0] K0 = 32'h2040_6080, K1 = 32'h1030_5070;

    logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, ctrl_word, io_enable;
    logic [1:0]  spi_master_sel;
    logic        bank_locked;
    int total = 0, bad = 0;

    logic [31:0] m_k0, m_k1, m_ctrl, m_io;

    always #2.5 clk = ~clk;

    cfgbank_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_word(ctrl_word),
        .io_enable(io_enable), .spi_master_sel(spi_master_sel), .bank_locked(bank_locked)
    );

    function automatic logic m_locked();
        return !(m_k0 == K0 && m_k1 == K1);
    endfunction

    function automatic logic [31:0] ctrl_after(logic [31:0] old, logic [31:0] w);
        logic [31:0] r = w;
        if (w[27]) r[27:26] = old[27:26];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        case (a)
            A_CTRL:  return m_ctrl;
            A_K0:    return m_k0;
            A_K1:    return m_k1;
            A_IO:    return m_io;
            A_STAT:  return {31'b0, m_locked()};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        logic lk = m_locked();
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            A_K0:   m_k0 = d;
            A_K1:   m_k1 = d;
            A_CTRL: if (!lk) m_ctrl = ctrl_after(m_ctrl, d);
            A_IO:   if (!lk) m_io = d;
            default: ;
        endcase
    endtask

    task automatic rd_chk(string req, logic [11:0] a);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic outs_chk(string req);
        chk({req, " ctrl_word"}, ctrl_word, m_ctrl);
        chk({req, " io_enable"}, io_enable, m_io);
        chk({req, " spi_sel"}, {30'b0, spi_master_sel}, {30'b0, m_ctrl[27:26]});
        chk({req, " locked"}, {31'b0, bank_locked}, {31'b0, m_locked()});
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        m_k0 = 0; m_k1 = 0; m_ctrl = 32'h0026_1889; m_io = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl reset", ctrl_word, 32'h0026_1889);
        chk("R1 io reset", io_enable, 32'h0);
        chk("R1 locked", {31'b0, bank_locked}, 32'h1);
        rd_chk("R1 key0 reset", A_K0);
        // R5 locked write dropped
        wr(A_CTRL, 32'h0400_0000);
        wr(A_IO, 32'hFFFF_FFFF);
        outs_chk("R5 locked drop");
        // R3 key1 first then key0
        wr(A_K1, K1);
        chk("R3 half open", {31'b0, bank_locked}, 32'h1);
        wr(A_K0, K0);
        chk("R3 open", {31'b0, bank_locked}, 32'h0);
        rd_chk("R2 key0 readback", A_K0);
        rd_chk("R2 key1 readback", A_K1);
        rd_chk("R8 status open", A_STAT);
        // R6 write lands, R10 select output
        wr(A_CTRL, 32'h0400_0001);
        outs_chk("R6 R10 ctrl write");
        chk("R10 spi master B", {30'b0, spi_master_sel}, 32'h1);
        wr(A_IO, 32'h0001_8034);
        outs_chk("R6 io write");
        // R7 reserved codes
        wr(A_CTRL, 32'h0C00_00F0);
        outs_chk("R7 reserved 11");
        chk("R7 sel kept", {30'b0, spi_master_sel}, 32'h1);
        wr(A_CTRL, 32'h0800_0000);
        outs_chk("R7 reserved 10");
        // R8 and R9 writes ignored
        wr(A_STAT, 32'h0);
        rd_chk("R8 status write ignored", A_STAT);
        wr(A_UNM, 32'hDEAD_BEEF);
        rd_chk("R9 unmapped reads zero", A_UNM);
        outs_chk("R9 unmapped write");
        // R4 relock via key0 with a near-miss value
        wr(A_K0, K0 ^ 32'h1);
        outs_chk("R4 relock");
        wr(A_IO, 32'h0);
        outs_chk("R4 R5 after relock");
        rd_chk("R9 read while locked", A_IO);
        // key0 then key1, relock via key1
        wr(A_K0, K0); wr(A_K1, K1);
        chk("R3 order 0-1", {31'b0, bank_locked}, 32'h0);
        wr(A_K1, 32'h0);
        outs_chk("R4 relock key1");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 7);
            logic [31:0] d = $urandom();
            case (op)
                0: wr(A_K0, ($urandom_range(0, 2) != 0) ? K0 : d);
                1: wr(A_K1, ($urandom_range(0, 2) != 0) ? K1 : d);
                2, 3: wr(A_CTRL, d);
                4: wr(A_IO, d);
                5: wr(A_STAT, d);
                6: wr(A_UNM, d);
                default: ;
            endcase
            outs_chk("R3 R4 R5 R6 R7 random");
            case ($urandom_range(0, 5))
                0: rd_chk("R2 R9 random read", A_CTRL);
                1: rd_chk("R2 random read", A_K0);
                2: rd_chk("R2 random read", A_K1);
                3: rd_chk("R9 random read", A_IO);
                4: rd_chk("R8 random read", A_STAT);
                default: rd_chk("R9 random read", A_UNM);
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule